// File: doc/BRIEF.md
# Narrowband Control Channel RE Address Generator

This block walks the resource elements of one subframe that carry a narrowband downlink control channel. For each modulated QPSK symbol it places an address into a flat frequency-domain sample buffer. A single start pulse loads the configuration: start OFDM symbol, number of PRB pairs (2, 4 or 6), antenna-port selector, first CCE, narrowband index, carrier width in RBs, FFT size and first carrier offset. The generator then scans symbol by symbol up to the last symbol of the subframe. In the four symbols that hold demodulation reference signals it skips the subcarriers those signals occupy, and it presents one candidate resource element on each clock.

Every address is built from three parts: a narrowband base offset, the symbol times the FFT size, and the subcarrier. The base offset depends on the carrier bandwidth and wraps when it runs past the FFT size. A one-sample shift is added for one of the two antenna-port groups. Resource elements that belong to CCEs below the first CCE are counted but not emitted. A done pulse marks the end of the scan. An unsupported configuration raises a one-cycle error pulse and starts no scan.

Top module: `ctl_re_addr_gen`

## Requirements
- R1: After an accepted start, each cycle holds one candidate RE. Candidates run from the start symbol to symbol 13 and, inside a symbol, in ascending subcarrier order from 0 to 12*NPRB-1. The address of a candidate is base + symbol*fft_size_i + subcarrier + port shift. The first candidate appears in the cycle after the accepting clock edge.
- R2: In symbols 5, 6, 12 and 13, subcarriers whose index mod 12 equals 0, 5 or 10 are never candidates. No cycle is spent on them.
- R3: With first CCE 0, the number of emitted addresses is 864, 792 or 720 for start symbol 1, 2 or 3 with 6 PRBs. With start symbol 1 it is 576 for 4 PRBs and 288 for 2 PRBs.
- R4: port_sel_i values 0 and 1 add 1 to every address. Values 2 and 3 add 0.
- R5: The first first_cce_i*H candidates are counted but not emitted (valid_o low), where H is 36, 33 or 30 for start symbol 1, 2 or 3. All later candidates are emitted on consecutive cycles.
- R6: base = first_carrier_i + 12*k + nb_idx_i*72, where k is 0 for 6 or 25 RBs, 1 for 15, 50 or 75 RBs, and 2 for 100 RBs.
- R7: If that base is greater than fft_size_i, fft_size_i-1 is subtracted from it.
- R8: A start with n_rb_i outside {6,15,25,50,75,100}, start_sym_i outside 1..3, or nprb_i outside {2,4,6} gives a one-cycle error_o pulse in the cycle after the start edge. It produces no valid_o and no done_o.
- R9: done_o is high for exactly one cycle, the cycle after the last candidate.
- R10: A start_i pulse that arrives while a scan is running is ignored. The running scan keeps its configuration and its address sequence.
- R11: During and after reset, valid_o, done_o and error_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; configuration sampled with it |
| start_sym_i | input | 2 | First OFDM symbol of the channel (1..3) |
| nprb_i | input | 3 | PRB pairs in the set (2, 4, 6) |
| port_sel_i | input | 2 | Two low RNTI bits choosing the port group |
| first_cce_i | input | 5 | First CCE index |
| nb_idx_i | input | 4 | Narrowband index |
| n_rb_i | input | 7 | Carrier bandwidth in RBs |
| fft_size_i | input | 12 | FFT size in samples |
| first_carrier_i | input | 12 | First carrier offset in samples |
| addr_o | output | 16 | Buffer address of the current RE |
| valid_o | output | 1 | addr_o holds an emitted RE |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| error_o | output | 1 | One-cycle unsupported-configuration pulse |

## Verification
On every cycle the assertions check four things: no candidate sits on a reference-signal subcarrier, emitted addresses rise strictly from one cycle to the next, a running scan cannot be dropped before its last candidate, and done and error are isolated single-cycle pulses that never coincide with a valid address. The exact address values are checked only by the bench scenarios, which compare against an independent model. So are the RE totals for each start symbol and PRB count, the CCE skip, the bandwidth-dependent base offset with its wraparound, the port shift, and the rejection of starts during a scan.

// File: rtl/ctl_re_pkg.sv
package ctl_re_pkg;
  localparam int unsigned SYM_LAST = 13;

  function automatic logic is_rs_sym(input logic [3:0] s);
    return (s == 4'd5) || (s == 4'd6) || (s == 4'd12) || (s == 4'd13);
  endfunction

  // {supported, k}
  function automatic logic [2:0] bw_class(input logic [6:0] nrb);
    case (nrb)
      7'd6, 7'd25:          return 3'b100;
      7'd15, 7'd50, 7'd75:  return 3'b101;
      7'd100:               return 3'b110;
      default:              return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/re_nb_base.sv
module re_nb_base
  import ctl_re_pkg::*;
#(
  parameter int FFT_W  = 12,
  parameter int ADDR_W = 16,
  parameter int CCE_W  = 5,
  parameter int NB_W   = 4,
  parameter int CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        start_sym_i,
  input  logic [2:0]        nprb_i,
  input  logic [1:0]        port_sel_i,
  input  logic [CCE_W-1:0]  first_cce_i,
  input  logic [NB_W-1:0]   nb_idx_i,
  input  logic [6:0]        n_rb_i,
  input  logic [FFT_W-1:0]  fft_size_i,
  input  logic [FFT_W-1:0]  first_carrier_i,
  output logic              cfg_ok_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              port_add_o,
  output logic [CNT_W-1:0]  skip_o
);
  logic [2:0]        cls;
  logic [ADDR_W-1:0] raw_base, base_d;
  logic [5:0]        half_bpc;

  assign cls      = bw_class(n_rb_i);
  assign cfg_ok_o = cls[2] && (start_sym_i != 2'd0) &&
                    (nprb_i == 3'd2 || nprb_i == 3'd4 || nprb_i == 3'd6);

  always_comb begin
    raw_base = ADDR_W'(first_carrier_i) + ADDR_W'(12 * cls[1:0]) + ADDR_W'(nb_idx_i) * ADDR_W'(72);
    base_d   = (raw_base > ADDR_W'(fft_size_i)) ?
               raw_base - (ADDR_W'(fft_size_i) - ADDR_W'(1)) : raw_base;
    case (start_sym_i)
      2'd2:    half_bpc = 6'd33;
      2'd3:    half_bpc = 6'd30;
      default: half_bpc = 6'd36;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o     <= '0;
      port_add_o <= 1'b0;
      skip_o     <= '0;
    end else if (load_i) begin
      base_o     <= base_d;
      port_add_o <= ~port_sel_i[1];
      skip_o     <= CNT_W'(first_cce_i) * CNT_W'(half_bpc);
    end
  end
endmodule

// File: rtl/re_scan.sv
module re_scan
  import ctl_re_pkg::*;
#(
  parameter int FFT_W  = 12,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [1:0]        start_sym_i,
  input  logic [2:0]        nprb_i,
  input  logic [FFT_W-1:0]  fft_size_i,
  output logic              active_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] sym_base_o,
  output logic [6:0]        sc_o
);
  logic [3:0]       sym, km, km_sum;
  logic [6:0]       sc_last;
  logic [FFT_W-1:0] fft_q;
  logic [1:0]       step;
  logic             next_rs;

  assign last_o  = active_o && (sym == 4'(SYM_LAST)) && (sc_o == sc_last);
  assign next_rs = is_rs_sym(sym + 4'd1);
  // jump over reference-signal subcarriers (mod 12 = 0, 5, 10)
  assign step    = (is_rs_sym(sym) && (km == 4'd4 || km == 4'd9 || km == 4'd11)) ? 2'd2 : 2'd1;
  assign km_sum  = km + 4'(step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      sym        <= '0;
      km         <= '0;
      sc_o       <= '0;
      sc_last    <= '0;
      fft_q      <= '0;
      sym_base_o <= '0;
    end else if (go_i) begin
      active_o   <= 1'b1;
      sym        <= 4'(start_sym_i);
      km         <= '0;
      sc_o       <= '0;
      fft_q      <= fft_size_i;
      sc_last    <= (nprb_i == 3'd2) ? 7'd23 : (nprb_i == 3'd4) ? 7'd47 : 7'd71;
      sym_base_o <= ADDR_W'(fft_size_i) * ADDR_W'(start_sym_i);
    end else if (active_o) begin
      if (last_o) begin
        active_o <= 1'b0;
      end else if (sc_o == sc_last) begin
        sym        <= sym + 4'd1;
        sym_base_o <= sym_base_o + ADDR_W'(fft_q);
        sc_o       <= next_rs ? 7'd1 : 7'd0;
        km         <= next_rs ? 4'd1 : 4'd0;
      end else begin
        sc_o <= sc_o + 7'(step);
        km   <= (km_sum >= 4'd12) ? km_sum - 4'd12 : km_sum;
      end
    end
  end

  p_rs_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && is_rs_sym(sym) |-> (km != 4'd0) && (km != 4'd5) && (km != 4'd10));
  p_sym_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (sym >= 4'd1) && (sym <= 4'(SYM_LAST)) && (sc_o <= sc_last));
endmodule

// File: rtl/ctl_re_addr_gen.sv
module ctl_re_addr_gen
  import ctl_re_pkg::*;
#(
  parameter int FFT_W  = 12,
  parameter int ADDR_W = 16,
  parameter int CCE_W  = 5,
  parameter int NB_W   = 4,
  parameter int CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        start_sym_i,
  input  logic [2:0]        nprb_i,
  input  logic [1:0]        port_sel_i,
  input  logic [CCE_W-1:0]  first_cce_i,
  input  logic [NB_W-1:0]   nb_idx_i,
  input  logic [6:0]        n_rb_i,
  input  logic [FFT_W-1:0]  fft_size_i,
  input  logic [FFT_W-1:0]  first_carrier_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              error_o
);
  logic              cfg_ok, accept, go, active, last, port_add;
  logic [ADDR_W-1:0] base, sym_base;
  logic [6:0]        sc;
  logic [CNT_W-1:0]  skip, re_cnt;

  assign accept = start_i && !active;
  assign go     = accept && cfg_ok;

  re_nb_base #(.FFT_W(FFT_W), .ADDR_W(ADDR_W), .CCE_W(CCE_W), .NB_W(NB_W), .CNT_W(CNT_W)) u_base (
    .clk_i, .rst_ni, .load_i(go), .start_sym_i, .nprb_i, .port_sel_i, .first_cce_i,
    .nb_idx_i, .n_rb_i, .fft_size_i, .first_carrier_i,
    .cfg_ok_o(cfg_ok), .base_o(base), .port_add_o(port_add), .skip_o(skip)
  );

  re_scan #(.FFT_W(FFT_W), .ADDR_W(ADDR_W)) u_scan (
    .clk_i, .rst_ni, .go_i(go), .start_sym_i, .nprb_i, .fft_size_i,
    .active_o(active), .last_o(last), .sym_base_o(sym_base), .sc_o(sc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_cnt  <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      done_o  <= last;
      error_o <= accept && !cfg_ok;
      if (go)          re_cnt <= '0;
      else if (active) re_cnt <= re_cnt + CNT_W'(1);
    end
  end

  assign valid_o = active && (re_cnt >= skip);
  assign addr_o  = base + sym_base + ADDR_W'(sc) + ADDR_W'(port_add);

  p_err_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);
  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !valid_o && !done_o);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_scan_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o && $past(active));
  p_scan_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !last |=> active);
  // holds for fft sizes of at least 72
  p_addr_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> addr_o > $past(addr_o));
endmodule

// File: tb/ctl_re_addr_gen_tb.sv
module ctl_re_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  start_sym = 2'd1;
  logic [2:0]  nprb = 3'd6;
  logic [1:0]  port_sel = 2'd0;
  logic [4:0]  first_cce = '0;
  logic [3:0]  nb_idx = '0;
  logic [6:0]  n_rb = 7'd25;
  logic [11:0] fft_size = 12'd512;
  logic [11:0] first_carrier = 12'd362;
  logic [15:0] addr;
  logic        valid, done, error;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  ctl_re_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_sym_i(start_sym), .nprb_i(nprb),
    .port_sel_i(port_sel), .first_cce_i(first_cce), .nb_idx_i(nb_idx), .n_rb_i(n_rb),
    .fft_size_i(fft_size), .first_carrier_i(first_carrier),
    .addr_o(addr), .valid_o(valid), .done_o(done), .error_o(error)
  );

  localparam int NV = 8;
  localparam int V_SS  [NV] = '{1, 2, 3, 1, 1, 1, 2, 3};
  localparam int V_NP  [NV] = '{6, 6, 6, 4, 2, 6, 6, 6};
  localparam int V_PS  [NV] = '{0, 2, 3, 1, 0, 2, 1, 0};
  localparam int V_CCE [NV] = '{0, 0, 0, 0, 0, 2, 4, 23};
  localparam int V_NB  [NV] = '{0, 1, 0, 0, 0, 3, 0, 2};
  localparam int V_NRB [NV] = '{25, 50, 100, 15, 6, 25, 75, 25};
  localparam int V_FFT [NV] = '{512, 1024, 2048, 256, 128, 512, 1024, 512};
  localparam int V_FCO [NV] = '{362, 724, 1448, 166, 92, 362, 574, 362};
  localparam int V_CNT [NV] = '{864, 792, 720, 576, 288, 792, 660, 30};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_base(input int nrb, input int nb, input int fco, input int fft);
    int k, b;
    k = (nrb == 100) ? 2 : (nrb == 15 || nrb == 50 || nrb == 75) ? 1 : 0;
    b = fco + 12 * k + 72 * nb;
    if (b > fft) b = b - (fft - 1);
    return b;
  endfunction

  // Runs vector v; when poke is set, a second start with altered inputs arrives mid-scan.
  task automatic run_vec(input int v, input bit poke);
    int base, half, sidx, cnt, got, mism, first_act, first_exp, ea;
    bit seen;
    base = exp_base(V_NRB[v], V_NB[v], V_FCO[v], V_FFT[v]);
    half = (V_SS[v] == 1) ? 36 : (V_SS[v] == 2) ? 33 : 30;
    sidx = V_CCE[v] * half;
    cnt = 0; got = 0; mism = 0; seen = 0; first_act = -1; first_exp = -1;
    start_sym = 2'(V_SS[v]); nprb = 3'(V_NP[v]); port_sel = 2'(V_PS[v]);
    first_cce = 5'(V_CCE[v]); nb_idx = 4'(V_NB[v]); n_rb = 7'(V_NRB[v]);
    fft_size = 12'(V_FFT[v]); first_carrier = 12'(V_FCO[v]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int l = V_SS[v]; l <= 13; l++) begin
      for (int k = 0; k < 12 * V_NP[v]; k++) begin
        if ((l == 5 || l == 6 || l == 12 || l == 13) && (k % 12 == 0 || k % 12 == 5 || k % 12 == 10))
          continue;
        ea = base + l * V_FFT[v] + k + ((V_PS[v] < 2) ? 1 : 0);
        if (valid !== (cnt >= sidx)) mism++;
        else if (valid && int'(addr) != ea) mism++;
        if (valid) begin
          got++;
          if (!seen) begin seen = 1; first_act = int'(addr); first_exp = ea; end
        end
        cnt++;
        if (poke && cnt == 100) begin
          start = 1'b1; n_rb = 7'd100; fft_size = 12'd2048; port_sel = ~port_sel; start_sym = 2'd3;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    // R1 R2 R4 R5: full address sequence against the model
    check(mism == 0, poke ? "R10 sequence under mid-scan start" : "R1 R2 R4 R5 address sequence", mism, 0);
    check(got == V_CNT[v], poke ? "R10 count" : "R3 R5 emitted count", got, V_CNT[v]);
    if (!poke) check(first_act == first_exp, "R6 R7 R4 first address", first_act, first_exp);
    check(done === 1'b1 && valid === 1'b0, "R9 done after last", int'(done), 1);
    @(negedge clk);
    check(done === 1'b0, "R9 done single cycle", int'(done), 0);
  endtask

  task automatic run_bad(input int ss, input int np, input int nrb, input string req);
    int extra;
    start_sym = 2'(ss); nprb = 3'(np); n_rb = 7'(nrb);
    fft_size = 12'd512; first_carrier = 12'd362; port_sel = 2'd0; first_cce = '0; nb_idx = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(error === 1'b1 && valid === 1'b0, req, int'(error), 1);
    extra = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (error !== 1'b0 || valid !== 1'b0 || done !== 1'b0) extra++;
    end
    check(extra == 0, {req, " quiet after pulse"}, extra, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 1'b0 && done === 1'b0 && error === 1'b0, "R11 in reset",
          int'({valid, done, error}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid === 1'b0 && done === 1'b0 && error === 1'b0, "R11 after reset",
          int'({valid, done, error}), 0);
    for (int v = 0; v < NV; v++) begin
      run_vec(v, 1'b0);
      @(negedge clk);
    end
    run_vec(0, 1'b1);   // R10
    @(negedge clk);
    run_bad(1, 6, 30, "R8 bad RB count");
    run_bad(0, 6, 25, "R8 bad start symbol");
    run_bad(1, 3, 25, "R8 bad PRB count");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule